// File: doc/BRIEF.md
# SD SPI-Mode Block Read Engine

This engine sits between an SPI byte shifter and a consumer of card data. It takes over once a read command (or a register read) has been issued to an SD card in SPI mode. For each expected block it first discards idle 0xFF bytes while it waits for the start token. It then passes a programmable number of payload bytes to a valid-qualified output stream. Last, it takes in the two-byte CRC16 trailer and, when enabled, checks it against a CRC computed over the payload.

The transfer ends with a single-cycle done pulse and an 8-bit status in the card's R1 error convention:
- 0x00 means success.
- 0x08 means a CRC mismatch.
- 0x80 means a bad start token, or a token wait that ran out of bytes.

Processing stops at the first block that fails. A 16-byte register read uses the same path with a block count of 1 and a block length of 16.

Top module: `sdr_blk_rd`

## Requirements
- R1: A pulse on start_i while idle latches blk_cnt_i, blk_len_i and crc_en_i. busy_o is high from the cycle after start until the done pulse.
- R2: While waiting for a token, each received 0xFF byte is skipped. If POLL_LIMIT consecutive 0xFF bytes arrive, the transfer ends with status 0x80. A 0xFE received after fewer than POLL_LIMIT idle bytes starts the block.
- R3: A first non-0xFF byte other than 0xFE ends the transfer with status 0x80.
- R4: After the token, exactly blk_len bytes are forwarded on data_o with data_vld_o, one cycle after each is received and in order. Cycles with rx_vld_i low consume nothing.
- R5: The two bytes after the payload form the received CRC, high byte first. It is compared with a CRC16 over the payload: polynomial 0x1021, initial value 0, bits taken MSB first. A mismatch with the check enabled ends the transfer with status 0x08.
- R6: With crc_en_i low at start, the trailer bytes are read and discarded, and a corrupt CRC still gives status 0x00.
- R7: For several blocks, each block repeats the token wait. done_o rises only after the last block's trailer, with status 0x00. A block count of 0 gives done with status 0x00 in the cycle after start.
- R8: After a failing block the engine is idle. Further received bytes produce no data_vld_o and no done_o.
- R9: done_o is a one-cycle pulse. status_o holds its value until the next start.
- R10: A register read (count 1, length 16) forwards 16 bytes and completes with status 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer (accepted when idle) |
| blk_cnt_i | input | CNT_W | Number of blocks to read |
| blk_len_i | input | LEN_W | Payload bytes per block |
| crc_en_i | input | 1 | Enable trailer CRC check |
| rx_vld_i | input | 1 | A received byte is present |
| rx_byte_i | input | 8 | Received byte from the shifter |
| busy_o | output | 1 | Transfer in progress |
| data_vld_o | output | 1 | Payload byte valid |
| data_o | output | 8 | Payload byte |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 8 | Completion status: 0x00, 0x08 or 0x80 |

## Verification
The bench builds the engine with POLL_LIMIT set to 20 instead of 3,000,000. This makes the token-wait expiry reachable, and the bench runs it both exactly at the limit and one byte short of it. CNT_W and LEN_W keep their defaults. This allows multi-block runs, zero-count starts and the 16-byte register read, with idle gaps inserted in the byte stream.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_TOKEN, S_DATA, S_CRC_HI, S_CRC_LO
  } sdr_state_e;

  localparam logic [7:0] BYTE_IDLE = 8'hFF;
  localparam logic [7:0] TOK_START = 8'hFE;
  localparam logic [7:0] ST_OK     = 8'h00;
  localparam logic [7:0] ST_CRC    = 8'h08;
  localparam logic [7:0] ST_GEN    = 8'h80;

  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ b[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction
endpackage

// File: rtl/sdr_crc16.sv
module sdr_crc16 (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  import sdr_pkg::*;

  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '0;
    else if (clr_i)  crc_q <= '0;
    else if (en_i)   crc_q <= crc16_byte(crc_q, byte_i);
  end

  assign crc_o = crc_q;

  a_r5_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (crc_q == 16'h0000));
endmodule

// File: rtl/sdr_poll_timer.sv
module sdr_poll_timer #(
  parameter int LIMIT = 3000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = inc_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (inc_i && !expire_o)  cnt_q <= cnt_q + 1'b1;
  end

  a_r2_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(LIMIT));
endmodule

// File: rtl/sdr_blk_rd.sv
module sdr_blk_rd #(
  parameter int POLL_LIMIT = 3000000,
  parameter int CNT_W      = 16,
  parameter int LEN_W      = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] blk_cnt_i,
  input  logic [LEN_W-1:0] blk_len_i,
  input  logic             crc_en_i,
  input  logic             rx_vld_i,
  input  logic [7:0]       rx_byte_i,
  output logic             busy_o,
  output logic             data_vld_o,
  output logic [7:0]       data_o,
  output logic             done_o,
  output logic [7:0]       status_o
);
  import sdr_pkg::*;

  sdr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q, idx_q;
  logic             crc_en_q;
  logic [7:0]       hi_q, data_q, status_q;
  logic             data_vld_q, done_q;
  logic [15:0]      crc_calc;
  logic             poll_expire;

  logic in_token, in_data;
  assign in_token = (state_q == S_TOKEN);
  assign in_data  = (state_q == S_DATA);

  sdr_poll_timer #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!in_token),
    .inc_i    (in_token && rx_vld_i && (rx_byte_i == BYTE_IDLE)),
    .expire_o (poll_expire)
  );

  sdr_crc16 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (in_token),
    .en_i   (in_data && rx_vld_i),
    .byte_i (rx_byte_i),
    .crc_o  (crc_calc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      len_q      <= '0;
      idx_q      <= '0;
      crc_en_q   <= 1'b0;
      hi_q       <= '0;
      data_q     <= '0;
      status_q   <= ST_OK;
      data_vld_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      data_vld_q <= 1'b0;
      done_q     <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          status_q <= ST_OK;
          cnt_q    <= blk_cnt_i;
          len_q    <= blk_len_i;
          crc_en_q <= crc_en_i;
          if (blk_cnt_i == '0) done_q  <= 1'b1;
          else                 state_q <= S_TOKEN;
        end
        S_TOKEN: if (rx_vld_i) begin
          if (rx_byte_i == TOK_START) begin
            idx_q   <= '0;
            state_q <= (len_q == '0) ? S_CRC_HI : S_DATA;
          end else if (rx_byte_i != BYTE_IDLE || poll_expire) begin
            state_q  <= S_IDLE;
            done_q   <= 1'b1;
            status_q <= ST_GEN;
          end
        end
        S_DATA: if (rx_vld_i) begin
          data_q     <= rx_byte_i;
          data_vld_q <= 1'b1;
          idx_q      <= idx_q + 1'b1;
          if (idx_q == len_q - 1'b1) state_q <= S_CRC_HI;
        end
        S_CRC_HI: if (rx_vld_i) begin
          hi_q    <= rx_byte_i;
          state_q <= S_CRC_LO;
        end
        S_CRC_LO: if (rx_vld_i) begin
          if (crc_en_q && ({hi_q, rx_byte_i} != crc_calc)) begin
            state_q  <= S_IDLE;
            done_q   <= 1'b1;
            status_q <= ST_CRC;
          end else if (cnt_q == CNT_W'(1)) begin
            cnt_q    <= '0;
            state_q  <= S_IDLE;
            done_q   <= 1'b1;
            status_q <= ST_OK;
          end else begin
            cnt_q   <= cnt_q - 1'b1;
            state_q <= S_TOKEN;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign data_vld_o = data_vld_q;
  assign data_o     = data_q;
  assign done_o     = done_q;
  assign status_o   = status_q;

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r4_data_in_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_vld_o |-> (busy_o && !done_o));
  a_r9_status_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(status_o));
  a_r1_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && (blk_cnt_i != '0)) |=> busy_o);
endmodule

// File: tb/sim_sdr_blk_rd.sv
module sim_sdr_blk_rd;
  localparam int CLK_PERIOD = 10;
  localparam int PL = 20;
  localparam int CW = 16;
  localparam int LW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, crc_en = 1'b1, rx_vld = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic [LW-1:0] len = '0;
  logic [7:0] rx_byte = 8'hFF;
  logic busy, dvld, done;
  logic [7:0] dout, status;

  int n_tests = 0, n_fail = 0;
  bit gaps = 0;
  logic [7:0] dq[$];
  logic [7:0] sq[$];
  string      tq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_blk_rd #(.POLL_LIMIT(PL), .CNT_W(CW), .LEN_W(LW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .blk_cnt_i(cnt),
    .blk_len_i(len), .crc_en_i(crc_en), .rx_vld_i(rx_vld), .rx_byte_i(rx_byte),
    .busy_o(busy), .data_vld_o(dvld), .data_o(dout), .done_o(done), .status_o(status));

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(logic [15:0] c, logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[15] ^ b[7-i]) r = (r << 1) ^ 16'h1021;
      else                r = r << 1;
    end
    return r;
  endfunction

  // monitor
  always @(negedge clk) if (rst_n) begin
    if (dvld) begin
      if (dq.size() == 0) chk(0, "R8 spurious data", dout, -1);
      else begin
        logic [7:0] e;
        e = dq.pop_front();
        chk(dout == e, "R4 payload byte", dout, e);
      end
    end
    if (done) begin
      if (sq.size() == 0) chk(0, "R8 spurious done", status, -1);
      else begin
        logic [7:0] e;
        string t;
        e = sq.pop_front();
        t = tq.pop_front();
        chk(status == e, t, status, e);
      end
    end
  end

  task automatic send(logic [7:0] b);
    @(negedge clk);
    rx_vld = 1'b1;
    rx_byte = b;
  endtask

  task automatic idle();
    @(negedge clk);
    rx_vld = 1'b0;
    rx_byte = 8'hFF;
  endtask

  task automatic expect_done(logic [7:0] s, string tag);
    sq.push_back(s);
    tq.push_back(tag);
  endtask

  task automatic go(int c, int l, bit ce);
    @(negedge clk);
    rx_vld = 1'b0;
    start = 1'b1; cnt = CW'(c); len = LW'(l); crc_en = ce;
    @(negedge clk);
    start = 1'b0;
    if (c != 0) chk(busy == 1'b1, "R1 busy after start", busy, 1);
  endtask

  task automatic blk(int nff, logic [7:0] tok, int l, int seed, bit bad, bit keep);
    logic [15:0] c = 16'h0000;
    repeat (nff) send(8'hFF);
    send(tok);
    if (tok != 8'hFE) return;
    for (int i = 0; i < l; i++) begin
      logic [7:0] b;
      b = 8'(seed * 37 + i * 11 + 3);
      c = ref_crc(c, b);
      if (keep) dq.push_back(b);
      send(b);
      if (gaps && (i % 3 == 1)) idle();
    end
    if (bad) c = c ^ 16'h0100;
    send(c[15:8]);
    send(c[7:0]);
  endtask

  task automatic settle(logic [7:0] s);
    idle();
    repeat (3) @(negedge clk);
    chk(sq.size() == 0, "R7 done observed", sq.size(), 0);
    chk(dq.size() == 0, "R4 payload count", dq.size(), 0);
    chk(!busy, "R8 idle after done", busy, 0);
    chk(status == s, "R9 status held", status, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !dvld && !done && status == 8'h00, "R1 reset state",
        {busy, dvld, done, status}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R5 single block, good CRC
    expect_done(8'h00, "R5 good crc status");
    go(1, 4, 1); blk(3, 8'hFE, 4, 1, 0, 1); settle(8'h00);

    // R7 three blocks, gaps in stream
    gaps = 1;
    expect_done(8'h00, "R7 multi block status");
    go(3, 8, 1);
    blk(0, 8'hFE, 8, 2, 0, 1); blk(5, 8'hFE, 8, 3, 0, 1); blk(1, 8'hFE, 8, 4, 0, 1);
    settle(8'h00);
    gaps = 0;

    // R5 bad CRC with check on, R8 stop
    expect_done(8'h08, "R5 crc mismatch status");
    go(2, 6, 1); blk(2, 8'hFE, 6, 5, 1, 1); settle(8'h08);
    blk(0, 8'hFE, 6, 6, 0, 0);
    settle(8'h08);

    // R6 bad CRC with check off
    expect_done(8'h00, "R6 crc disabled status");
    go(1, 5, 0); blk(1, 8'hFE, 5, 7, 1, 1); settle(8'h00);

    // R3 bad token
    expect_done(8'h80, "R3 bad token status");
    go(1, 4, 1); blk(2, 8'hFC, 4, 8, 0, 0); settle(8'h80);

    // R2 timeout at exactly PL idle bytes
    expect_done(8'h80, "R2 poll timeout status");
    go(1, 4, 1); repeat (PL) send(8'hFF); settle(8'h80);

    // R2 token one byte before limit
    expect_done(8'h00, "R2 token before limit");
    go(1, 4, 1); blk(PL - 1, 8'hFE, 4, 9, 0, 1); settle(8'h00);

    // R10 register read
    expect_done(8'h00, "R10 register read status");
    go(1, 16, 1); blk(2, 8'hFE, 16, 10, 0, 1); settle(8'h00);

    // R8 second block bad token after good first
    expect_done(8'h80, "R8 stop at failing block");
    go(3, 4, 1); blk(0, 8'hFE, 4, 11, 0, 1); blk(1, 8'h00, 4, 12, 0, 0);
    settle(8'h80);

    // R7 zero count
    expect_done(8'h00, "R7 zero count status");
    go(0, 4, 1); settle(8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule